// File: doc/BRIEF.md
# SPI Receive/Transmit FIFO Request Controller

This block is the buffering and request core of a serial peripheral controller. A four-entry receive FIFO collects words from the serial side, and a one-word holding register sits in front of it. A four-entry transmit FIFO is filled by host writes and drained each time the serial side needs a word. The shifter, chip-select timing and clock generation sit outside the block. Two strobes stand in for them: `xferDone`, which presents a completed received word on `rxWord`, and `txWordReq`, which takes the next word from `txWord` in the same cycle.

The block raises a drain request while received data is waiting. A routing bit sends that request to either an interrupt line or a DMA line. When a word arrives while both the FIFO and the holding register are full, an overflow flag is set. A policy bit then either keeps the new word in the holding register or throws it away. A transmit request that finds the FIFO empty sets an underflow flag and sends zeros. The two flags are ORed onto an overrun line.

A disable bit, set out of reset, puts the block in a dormant mode. In this mode every register still reads back correctly, but FIFO pushes, pops, flushes, serial strobes, flag clears, FIFO-size changes and counter writes have no effect.

Top module: `spiq_core`

## Requirements
- R1: `irqDrain | dmaDrain` is high exactly when the receive FIFO count (status bits [7:4]) is non-zero and the drain-enable bit (config bit 2) is set.
- R2: Config bit 3 routes the drain request. When it is 1 the request appears on `dmaDrain`; when it is 0 it appears on `irqDrain`. The two outputs are never high together.
- R3: A `xferDone` that finds the receive FIFO full and the holding register occupied sets the overflow flag (status bit 0) on the next clock. Status bit 2 shows that the holding register is occupied.
- R4: `irqOverflow` equals the overflow flag ANDed with the overflow-enable bit (config bit 4).
- R5: When config bit 1 is 1, the word that caused an overflow replaces the holding register contents and is read out later. When config bit 1 is 0, that word is discarded.
- R6: `overrunReq` is the OR of the overflow flag and the underflow flag (status bit 1).
- R7: After reset the config register (address 0) reads 0x0001, with disable in bit 0. Status (address 1) reads 0 and the transfer counter (address 4) reads 0.
- R8: While disabled, reading the pop port (address 3), writing the push port (address 2), the flush bits (config bits 8 and 9, which flush transmit and receive respectively), `xferDone` and `txWordReq` leave both FIFO counts and the holding register unchanged.
- R9: While disabled, writes to status, to the FIFO-size bits (config bits 5 and 6) and to the transfer counter have no effect, so the request outputs stay as they were.
- R10: `txWordReq` returns the oldest transmit word on `txWord` in the same cycle and removes it. With an empty FIFO, `txWord` is 0 and the underflow flag sets.
- R11: Writing 1 to a status flag bit clears it. If a set event happens in the same cycle, the flag stays set.
- R12: Config bit 6 (receive) and bit 5 (transmit) limit the corresponding FIFO to one entry.
- R13: Received words come out of address 3 in arrival order, with the holding register moving into the FIFO as soon as there is room, including in the cycle of a pop. A flush empties the FIFO, and for receive also the holding register. The transmit count is at status bits [11:8].
- R14: The transfer counter at address 4 counts each `xferDone` taken while enabled, and a host write loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops at address 3) |
| regAddr | input | 3 | Register address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr`, combinational |
| xferDone | input | 1 | A serial transfer completed with `rxWord` |
| rxWord | input | 16 | Received word |
| txWordReq | input | 1 | Serial side takes the next transmit word |
| txWord | output | 16 | Transmit word, 0 on underflow |
| irqDrain | output | 1 | Drain request, interrupt route |
| dmaDrain | output | 1 | Drain request, DMA route |
| irqOverflow | output | 1 | Enabled overflow interrupt |
| overrunReq | output | 1 | Overflow OR underflow |

## Verification
If the holding-register valid bit is wrong, status bit 2 and the count show it on the next status read, and a word is lost or repeated at the following pop. A pointer error shows up as data out of order on the very next pop. A disable gate that leaks shows up as a count change in the status read right after the blocked access. A wrong flag priority shows up as an overrun line that is low one cycle after an overflow that happened together with a clear.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  typedef struct packed {
    logic rxDirect;
    logic rxFromShift;
    logic shiftLoad;
    logic rxPop;
    logic rxFlush;
    logic txPush;
    logic txPop;
    logic txFlush;
  } spiqStrobe_t;

  localparam int ADDR_CFG    = 0;
  localparam int ADDR_STAT   = 1;
  localparam int ADDR_TXPUSH = 2;
  localparam int ADDR_RXPOP  = 3;
  localparam int ADDR_XCNT   = 4;

  localparam int CB_DISABLE = 0;
  localparam int CB_KEEP    = 1;
  localparam int CB_DRAINEN = 2;
  localparam int CB_TODMA   = 3;
  localparam int CB_OVFEN   = 4;
  localparam int CB_TXOFF   = 5;
  localparam int CB_RXOFF   = 6;
  localparam int CB_TXFLUSH = 8;
  localparam int CB_RXFLUSH = 9;
endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wr,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rd,
  input  logic             flush,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr && !flush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wr) wrPtr <= bump(wrPtr);
      if (rd) rdPtr <= bump(rdPtr);
      case ({wr, rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rdPtr];

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R13
  AST_FIFO_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    rd |-> count != '0); // R13
endmodule

// File: rtl/spiq_data.sv
module spiq_data
  import spiq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiqStrobe_t       strobe,
  input  logic [DATA_W-1:0] rxWord,
  input  logic [DATA_W-1:0] txPushData,
  output logic [DATA_W-1:0] rxHead,
  output logic [DATA_W-1:0] txHead,
  output logic [CW-1:0]     rxCount,
  output logic [CW-1:0]     txCount
);
  logic [DATA_W-1:0] shiftData;
  logic [DATA_W-1:0] rxFifoIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftData <= '0;
    else if (strobe.shiftLoad) shiftData <= rxWord;
  end

  assign rxFifoIn = strobe.rxFromShift ? shiftData : rxWord;

  spiq_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN),
    .wr(strobe.rxDirect | strobe.rxFromShift), .wrData(rxFifoIn),
    .rd(strobe.rxPop), .flush(strobe.rxFlush),
    .head(rxHead), .count(rxCount)
  );

  spiq_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN),
    .wr(strobe.txPush), .wrData(txPushData),
    .rd(strobe.txPop), .flush(strobe.txFlush),
    .head(txHead), .count(txCount)
  );

  AST_ONE_RX_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.rxDirect && strobe.rxFromShift)); // R13
endmodule

// File: rtl/spiq_ctrl.sv
module spiq_ctrl
  import spiq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 3,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              xferDone,
  input  logic              txWordReq,
  input  logic [CW-1:0]     rxCount,
  input  logic [CW-1:0]     txCount,
  input  logic [DATA_W-1:0] rxHead,
  input  logic [DATA_W-1:0] txHead,
  output spiqStrobe_t       strobe,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] txWord,
  output logic              irqDrain,
  output logic              dmaDrain,
  output logic              irqOverflow,
  output logic              overrunReq
);
  localparam logic [CW-1:0] FULL_DEPTH = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_DEPTH  = CW'(1);

  logic cfgDisable, cfgKeep, cfgDrainEn, cfgToDma, cfgOvfEn, cfgTxOff, cfgRxOff;
  logic rxOvfFlag, txUnfFlag, shiftValid;
  logic [DATA_W-1:0] xferCount;

  logic enabled, wrCfg, wrStat, wrXcnt, wrPush, rdPop;
  logic flushTx, flushRx, rxRoom, xferGo, ovfEvent, unfEvent;
  logic [CW-1:0] rxCap, txCap;

  assign enabled = !cfgDisable;
  assign wrCfg   = regWrEn && regAddr == ADDR_W'(ADDR_CFG);
  assign wrStat  = regWrEn && regAddr == ADDR_W'(ADDR_STAT) && enabled;
  assign wrXcnt  = regWrEn && regAddr == ADDR_W'(ADDR_XCNT) && enabled;
  assign wrPush  = regWrEn && regAddr == ADDR_W'(ADDR_TXPUSH);
  assign rdPop   = regRdEn && regAddr == ADDR_W'(ADDR_RXPOP);
  assign flushTx = wrCfg && regWrData[CB_TXFLUSH] && enabled;
  assign flushRx = wrCfg && regWrData[CB_RXFLUSH] && enabled;

  assign rxCap = cfgRxOff ? ONE_DEPTH : FULL_DEPTH;
  assign txCap = cfgTxOff ? ONE_DEPTH : FULL_DEPTH;

  always_comb begin
    strobe = '0;
    strobe.rxPop   = rdPop && enabled && rxCount != '0 && !flushRx;
    strobe.rxFlush = flushRx;
    strobe.txFlush = flushTx;
    strobe.txPush  = wrPush && enabled && txCount < txCap && !flushTx;
    strobe.txPop   = txWordReq && enabled && txCount != '0 && !flushTx;
    rxRoom = (rxCount < rxCap) || strobe.rxPop;
    xferGo = xferDone && enabled;
    strobe.rxFromShift = shiftValid && rxRoom && enabled && !flushRx;
    if (xferGo && !flushRx) begin
      if (!shiftValid && rxRoom) strobe.rxDirect = 1'b1;
      else if (!shiftValid || rxRoom) strobe.shiftLoad = 1'b1;
      else strobe.shiftLoad = cfgKeep;
    end
    ovfEvent = xferGo && shiftValid && !rxRoom;
    unfEvent = txWordReq && enabled && txCount == '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgDisable <= 1'b1;
      cfgKeep    <= 1'b0;
      cfgDrainEn <= 1'b0;
      cfgToDma   <= 1'b0;
      cfgOvfEn   <= 1'b0;
      cfgTxOff   <= 1'b0;
      cfgRxOff   <= 1'b0;
    end else if (wrCfg) begin
      cfgDisable <= regWrData[CB_DISABLE];
      cfgKeep    <= regWrData[CB_KEEP];
      cfgDrainEn <= regWrData[CB_DRAINEN];
      cfgToDma   <= regWrData[CB_TODMA];
      cfgOvfEn   <= regWrData[CB_OVFEN];
      if (enabled) begin
        cfgTxOff <= regWrData[CB_TXOFF];
        cfgRxOff <= regWrData[CB_RXOFF];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxOvfFlag  <= 1'b0;
      txUnfFlag  <= 1'b0;
      shiftValid <= 1'b0;
      xferCount  <= '0;
    end else begin
      rxOvfFlag <= ovfEvent || (rxOvfFlag && !(wrStat && regWrData[0]));
      txUnfFlag <= unfEvent || (txUnfFlag && !(wrStat && regWrData[1]));
      if (flushRx) shiftValid <= 1'b0;
      else if (strobe.shiftLoad) shiftValid <= 1'b1;
      else if (strobe.rxFromShift) shiftValid <= 1'b0;
      if (wrXcnt) xferCount <= regWrData;
      else if (xferGo) xferCount <= xferCount + 1'b1;
    end
  end

  always_comb begin
    regRdData = '0;
    case (int'(regAddr))
      ADDR_CFG: begin
        regRdData[CB_DISABLE] = cfgDisable;
        regRdData[CB_KEEP]    = cfgKeep;
        regRdData[CB_DRAINEN] = cfgDrainEn;
        regRdData[CB_TODMA]   = cfgToDma;
        regRdData[CB_OVFEN]   = cfgOvfEn;
        regRdData[CB_TXOFF]   = cfgTxOff;
        regRdData[CB_RXOFF]   = cfgRxOff;
      end
      ADDR_STAT: begin
        regRdData[0]    = rxOvfFlag;
        regRdData[1]    = txUnfFlag;
        regRdData[2]    = shiftValid;
        regRdData[7:4]  = 4'(rxCount);
        regRdData[11:8] = 4'(txCount);
      end
      ADDR_RXPOP: regRdData = (rxCount != '0) ? rxHead : '0;
      ADDR_XCNT:  regRdData = xferCount;
      default:    regRdData = '0;
    endcase
  end

  assign txWord      = strobe.txPop ? txHead : '0;
  assign irqDrain    = cfgDrainEn && rxCount != '0 && !cfgToDma;
  assign dmaDrain    = cfgDrainEn && rxCount != '0 && cfgToDma;
  assign irqOverflow = rxOvfFlag && cfgOvfEn;
  assign overrunReq  = rxOvfFlag || txUnfFlag;

  AST_DRAIN_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    !(irqDrain && dmaDrain)); // R2
  AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && !cfgDisable && shiftValid && rxCount >= rxCap && !strobe.rxPop) |=> rxOvfFlag); // R3
  AST_OVF_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irqOverflow |-> cfgOvfEn); // R4
  AST_DISABLE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    cfgDisable |=> $stable(rxCount) && $stable(txCount)); // R8
  AST_DISABLE_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDisable && rxOvfFlag && txUnfFlag) |=> rxOvfFlag && txUnfFlag); // R9
  AST_UNF_ON_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (txWordReq && !cfgDisable && txCount == '0) |=> txUnfFlag); // R10
endmodule

// File: rtl/spiq_core.sv
module spiq_core
  import spiq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              xferDone,
  input  logic [DATA_W-1:0] rxWord,
  input  logic              txWordReq,
  output logic [DATA_W-1:0] txWord,
  output logic              irqDrain,
  output logic              dmaDrain,
  output logic              irqOverflow,
  output logic              overrunReq
);
  localparam int CW = $clog2(DEPTH + 1);

  spiqStrobe_t strobe;
  logic [CW-1:0] rxCount, txCount;
  logic [DATA_W-1:0] rxHead, txHead;

  spiq_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .xferDone(xferDone), .txWordReq(txWordReq),
    .rxCount(rxCount), .txCount(txCount), .rxHead(rxHead), .txHead(txHead),
    .strobe(strobe), .regRdData(regRdData), .txWord(txWord),
    .irqDrain(irqDrain), .dmaDrain(dmaDrain),
    .irqOverflow(irqOverflow), .overrunReq(overrunReq)
  );

  spiq_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rxWord(rxWord), .txPushData(regWrData),
    .rxHead(rxHead), .txHead(txHead),
    .rxCount(rxCount), .txCount(txCount)
  );
endmodule

// File: tb/sim_spiq_core.sv
module sim_spiq_core;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0, xferDone = 1'b0, txWordReq = 1'b0;
  logic [2:0] regAddr = '0;
  logic [15:0] regWrData = '0, rxWord = '0;
  logic [15:0] regRdData, txWord;
  logic irqDrain, dmaDrain, irqOverflow, overrunReq;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  spiq_core u0 (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .xferDone(xferDone), .rxWord(rxWord),
    .txWordReq(txWordReq), .txWord(txWord),
    .irqDrain(irqDrain), .dmaDrain(dmaDrain),
    .irqOverflow(irqOverflow), .overrunReq(overrunReq)
  );

  // vector: op[40:39] addr[38:36] data[35:20] expect[19:4] tag[3:0]
  // op 0 write, 1 read and compare, 2 serial word in, 3 transmit take and compare
  localparam int NV = 43;
  localparam logic [40:0] VEC [NV] = '{
    {2'd1, 3'd0, 16'h0000, 16'h0001, 4'd7},   // R7 config after reset
    {2'd1, 3'd1, 16'h0000, 16'h0000, 4'd7},   // R7 status after reset
    {2'd1, 3'd4, 16'h0000, 16'h0000, 4'd7},   // R7 counter after reset
    {2'd0, 3'd0, 16'h0014, 16'h0000, 4'd7},
    {2'd0, 3'd2, 16'h1111, 16'h0000, 4'd10},
    {2'd0, 3'd2, 16'h2222, 16'h0000, 4'd10},
    {2'd1, 3'd1, 16'h0000, 16'h0200, 4'd13},  // R13 tx count
    {2'd3, 3'd0, 16'h0000, 16'h1111, 4'd10},  // R10 order
    {2'd3, 3'd0, 16'h0000, 16'h2222, 4'd10},
    {2'd3, 3'd0, 16'h0000, 16'h0000, 4'd10},  // R10 zeros when empty
    {2'd1, 3'd1, 16'h0000, 16'h0002, 4'd10},  // R10 underflow flag
    {2'd0, 3'd1, 16'h0002, 16'h0000, 4'd11},
    {2'd1, 3'd1, 16'h0000, 16'h0000, 4'd11},  // R11 cleared
    {2'd2, 3'd0, 16'hA001, 16'h0000, 4'd3},
    {2'd2, 3'd0, 16'hA002, 16'h0000, 4'd3},
    {2'd2, 3'd0, 16'hA003, 16'h0000, 4'd3},
    {2'd2, 3'd0, 16'hA004, 16'h0000, 4'd3},
    {2'd2, 3'd0, 16'hA005, 16'h0000, 4'd3},
    {2'd2, 3'd0, 16'hA006, 16'h0000, 4'd3},
    {2'd1, 3'd1, 16'h0000, 16'h0045, 4'd3},   // R3 ovf, holding full, count 4
    {2'd1, 3'd3, 16'h0000, 16'hA001, 4'd13},
    {2'd1, 3'd1, 16'h0000, 16'h0041, 4'd13},  // R13 holding moved in pop cycle
    {2'd1, 3'd3, 16'h0000, 16'hA002, 4'd13},
    {2'd1, 3'd3, 16'h0000, 16'hA003, 4'd13},
    {2'd1, 3'd3, 16'h0000, 16'hA004, 4'd13},
    {2'd1, 3'd3, 16'h0000, 16'hA005, 4'd5},   // R5 A006 dropped
    {2'd1, 3'd1, 16'h0000, 16'h0001, 4'd5},
    {2'd0, 3'd1, 16'h0001, 16'h0000, 4'd11},
    {2'd1, 3'd1, 16'h0000, 16'h0000, 4'd11},
    {2'd0, 3'd0, 16'h0016, 16'h0000, 4'd5},
    {2'd2, 3'd0, 16'hB001, 16'h0000, 4'd5},
    {2'd2, 3'd0, 16'hB002, 16'h0000, 4'd5},
    {2'd2, 3'd0, 16'hB003, 16'h0000, 4'd5},
    {2'd2, 3'd0, 16'hB004, 16'h0000, 4'd5},
    {2'd2, 3'd0, 16'hB005, 16'h0000, 4'd5},
    {2'd2, 3'd0, 16'hB006, 16'h0000, 4'd5},
    {2'd1, 3'd3, 16'h0000, 16'hB001, 4'd5},
    {2'd1, 3'd3, 16'h0000, 16'hB002, 4'd5},
    {2'd1, 3'd3, 16'h0000, 16'hB003, 4'd5},
    {2'd1, 3'd3, 16'h0000, 16'hB004, 4'd5},
    {2'd1, 3'd3, 16'h0000, 16'hB006, 4'd5},   // R5 kept word replaced B005
    {2'd1, 3'd4, 16'h0000, 16'h000C, 4'd14},  // R14 twelve transfers
    {2'd0, 3'd1, 16'h0001, 16'h0000, 4'd11}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1 regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 v = regRdData;
    @(posedge clk); #1 regRdEn = 1'b0;
  endtask

  task automatic xfer(input logic [15:0] d);
    @(negedge clk);
    rxWord = d; xferDone = 1'b1;
    @(posedge clk); #1 xferDone = 1'b0;
  endtask

  task automatic txTake(output logic [15:0] v);
    @(negedge clk);
    txWordReq = 1'b1;
    #1 v = txWord;
    @(posedge clk); #1 txWordReq = 1'b0;
  endtask

  task automatic peek(output logic [3:0] v);
    @(negedge clk);
    #1 v = {irqDrain, dmaDrain, irqOverflow, overrunReq};
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] v;
    logic [3:0] o;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    peek(o); chk("R7 outputs after reset", 16'(o), 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [2:0] a;
      logic [15:0] d, e;
      string msg;
      {op, a, d, e} = VEC[i][40:4];
      msg = $sformatf("R%0d table step %0d", VEC[i][3:0], i);
      case (op)
        2'd0: wr(a, d);
        2'd1: begin rd(a, v); chk(msg, v, e); end
        2'd2: xfer(d);
        default: begin txTake(v); chk(msg, v, e); end
      endcase
    end

    // R1 / R2 drain routing; config now 0x0016
    xfer(16'hC001);
    peek(o); chk("R1 R2 drain on interrupt", 16'(o[3:2]), 16'h2);
    wr(3'd0, 16'h001E);
    peek(o); chk("R2 drain on dma", 16'(o[3:2]), 16'h1);
    wr(3'd0, 16'h001A);
    peek(o); chk("R1 drain disabled", 16'(o[3:2]), 16'h0);
    wr(3'd0, 16'h0016);

    // R4 / R6 overflow request
    xfer(16'hC002); xfer(16'hC003); xfer(16'hC004); xfer(16'hC005); xfer(16'hC006);
    peek(o); chk("R4 R6 overflow irq and overrun", 16'(o[1:0]), 16'h3);
    wr(3'd0, 16'h0006);
    peek(o); chk("R4 irq masked, R6 overrun held", 16'(o[1:0]), 16'h1);
    wr(3'd1, 16'h0001);
    peek(o); chk("R6 overrun low after clear", 16'(o[0]), 16'h0);
    txTake(v);
    peek(o); chk("R6 overrun from underflow", 16'(o[0]), 16'h1);
    wr(3'd1, 16'h0002);

    // R11 set wins over clear in the same cycle
    @(negedge clk);
    rxWord = 16'hC007; xferDone = 1'b1;
    regAddr = 3'd1; regWrData = 16'h0001; regWrEn = 1'b1;
    @(posedge clk); #1 begin xferDone = 1'b0; regWrEn = 1'b0; end
    rd(3'd1, v); chk("R11 set beats clear", v, 16'h0045);
    wr(3'd1, 16'h0001);

    // R8 / R9 disable mode
    txTake(v);
    wr(3'd2, 16'h7777);
    wr(3'd0, 16'h0007);
    rd(3'd1, v); chk("R8 status on entering disable", v, 16'h0146);
    rd(3'd3, v); chk("R8 pop reads head", v, 16'hC001);
    rd(3'd1, v); chk("R8 pop ignored", v, 16'h0146);
    wr(3'd2, 16'h8888);
    txTake(v); chk("R8 transmit take gives zero", v, 16'h0000);
    xfer(16'hEEEE);
    rd(3'd1, v); chk("R8 push, take, word ignored", v, 16'h0146);
    wr(3'd1, 16'h0003);
    rd(3'd1, v); chk("R9 flag clear ignored", v, 16'h0146);
    wr(3'd0, 16'h0367);
    rd(3'd1, v); chk("R8 flush ignored", v, 16'h0146);
    rd(3'd0, v); chk("R9 fifo size bits ignored", v, 16'h0007);
    peek(o); chk("R9 requests held", 16'(o), 16'h9);
    wr(3'd4, 16'h5555);
    rd(3'd4, v); chk("R9 R14 counter write ignored", v, 16'h0013);

    // R13 flush after re-enable
    wr(3'd0, 16'h0006);
    wr(3'd0, 16'h0306);
    rd(3'd1, v); chk("R13 flush empties both", v, 16'h0002);
    wr(3'd4, 16'h0100);
    xfer(16'h1234);
    rd(3'd4, v); chk("R14 counter loaded then counted", v, 16'h0101);

    // R12 one-entry receive FIFO, drop policy
    wr(3'd0, 16'h0044);
    rd(3'd1, v); chk("R12 status before", v, 16'h0012);
    rd(3'd3, v); chk("R12 drain old word", v, 16'h1234);
    xfer(16'hD001); xfer(16'hD002); xfer(16'hD003);
    rd(3'd1, v); chk("R12 depth one overflow", v, 16'h0017);
    rd(3'd3, v); chk("R12 first", v, 16'hD001);
    rd(3'd3, v); chk("R12 second from holding", v, 16'hD002);
    rd(3'd1, v); chk("R12 empty after", v, 16'h0003);

    summary();
  end
endmodule